// File: doc/BRIEF.md
# Machine-Cycle Reset Sequencer

This block produces the synchronous internal reset for a small processor core whose machine cycle spans a fixed number of oscillator clocks (twelve by default). An asynchronous, active-low external reset request is brought into the clock domain through a short flop chain. A free-running phase counter marks the end of each machine cycle, and the request is sampled only there. The internal reset turns on once two consecutive boundary samples read low. It stays on while the samples keep reading low and turns off at the first boundary that samples high.

A watchdog request is a single-clock pulse. It forces the internal reset for exactly one machine cycle, whatever the external pin is doing. While the internal reset is on, the output enables of the two bus-strobe pins (address latch strobe and program fetch strobe) are removed, so both pins act as inputs. A one-clock strobe marks each clock in which the internal reset goes from on to off.

Top module: `mc_reset_seq`

## Requirements
- R1: The external request `extRstN` is active low (0 = reset requested). It passes through a two-flop synchronizer that initialises to "not requesting". A level change is therefore visible to the boundary sample two clocks after it is applied.
- R2: The phase counter counts 0 to CYCLE_CLKS-1 and wraps. It is cleared only by `porN`. The boundary sample is taken on the edge where the phase is CYCLE_CLKS-1, so the first sample after `porN` rises is taken on the 12th rising edge, and further samples follow every 12 edges.
- R3: `coreRst` goes high in the clock that follows the boundary edge at which the second consecutive low sample is taken. With `extRstN` held low across the release of `porN`, this is the clock after the 24th edge.
- R4: If one low sample is followed by a high sample, `coreRst` never goes high. A low level lasting exactly CYCLE_CLKS clocks gives such a single sample.
- R5: Once on, `coreRst` stays high through every boundary that samples low.
- R6: An externally caused `coreRst` drops in the clock after the first boundary edge that samples high. It drops between 3 and 14 clocks after `extRstN` rises.
- R7: A one-clock pulse on `wdtReq` drives `coreRst` high from the next clock for exactly CYCLE_CLKS clocks, independent of `extRstN`. A new pulse restarts the window.
- R8: `aleOe` and `psenOe` are both 0 (pins are inputs) whenever `coreRst` is 1, and both 1 otherwise.
- R9: `relStrobe` is 1 for exactly the first clock in which `coreRst` is 0 after being 1, and is 0 at all other times.
- R10: While `porN` is low, `coreRst` and `relStrobe` are 0 and `aleOe` and `psenOe` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on initialisation, active low, asynchronous |
| extRstN | input | 1 | External reset request, active low, asynchronous |
| wdtReq | input | 1 | Watchdog reset request, one-clock pulse |
| coreRst | output | 1 | Synchronous internal reset to the core, active high |
| aleOe | output | 1 | Output enable for the address latch strobe pin |
| psenOe | output | 1 | Output enable for the program fetch strobe pin |
| relStrobe | output | 1 | One-clock pulse in the first clock after reset release |

## Verification
If the phase counter is wrong, reset assertion and release move away from the 12-clock grid, and this shows within one or two machine cycles of an external low. If the qualification state is wrong, a single-sample glitch either produces a reset or a real request is missed; both show at `coreRst` by the second boundary after the stimulus. If the watchdog window counter is wrong, the reset pulse after `wdtReq` is shorter or longer than twelve clocks, and the release strobe appears in the wrong clock.

// File: rtl/mcrst_pkg.sv
package mcrst_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic extHold;   // external source currently holds reset
    logic wdtLoad;   // (re)start the one-machine-cycle watchdog window
  } mcCtl_t;

  // Qualification state of the external request
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,  // last sample high
    ST_LOW1 = 2'd1,  // one low sample seen
    ST_HOLD = 2'd2   // two or more consecutive low samples
  } extState_e;

endpackage

// File: rtl/mcrst_datapath.sv
module mcrst_datapath
  import mcrst_pkg::*;
#(
  parameter int CYCLE_CLKS  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   porN,
  input  logic   extRstN,
  input  mcCtl_t ctl,
  output logic   boundary,
  output logic   sampledLow,
  output logic   coreRst,
  output logic   aleOe,
  output logic   psenOe,
  output logic   relStrobe
);

  localparam int PH_W  = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam int WDT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CYCLE_CLKS - 1);
  localparam logic [WDT_W-1:0] WDT_LOAD = WDT_W'(CYCLE_CLKS);

  // Synchronizer chain, initialised to "not requesting"
  logic [SYNC_STAGES-1:0] syncQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge porN) begin
          if (!porN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= extRstN;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge porN) begin
          if (!porN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign sampledLow = ~syncQ[SYNC_STAGES-1];

  // Free-running machine-cycle phase, cleared only by power-on init
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  assign boundary = (phase == PH_LAST);

  // Watchdog window: one machine cycle of forced reset
  logic [WDT_W-1:0] wdtCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              wdtCnt <= '0;
    else if (ctl.wdtLoad)   wdtCnt <= WDT_LOAD;
    else if (wdtCnt != '0)  wdtCnt <= wdtCnt - 1'b1;
  end

  // Output stage
  logic rstNow;
  logic rstPrev;

  assign rstNow = ctl.extHold | (wdtCnt != '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) rstPrev <= 1'b0;
    else       rstPrev <= rstNow;
  end

  assign coreRst   = rstNow;
  assign aleOe     = ~rstNow;
  assign psenOe    = ~rstNow;
  assign relStrobe = rstPrev & ~rstNow;

endmodule

// File: rtl/mcrst_control.sv
module mcrst_control
  import mcrst_pkg::*;
(
  input  logic   clk,
  input  logic   porN,
  input  logic   boundary,
  input  logic   sampledLow,
  input  logic   wdtReq,
  output mcCtl_t ctl
);

  extState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (boundary) begin
      unique case (state)
        ST_RUN:  stateNext = sampledLow ? ST_LOW1 : ST_RUN;
        ST_LOW1: stateNext = sampledLow ? ST_HOLD : ST_RUN;
        ST_HOLD: stateNext = sampledLow ? ST_HOLD : ST_RUN;
        default: stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.extHold = (state == ST_HOLD);
    ctl.wdtLoad = wdtReq;
  end

endmodule

// File: rtl/mc_reset_seq.sv
module mc_reset_seq
  import mcrst_pkg::*;
#(
  parameter int CYCLE_CLKS  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic extRstN,
  input  logic wdtReq,
  output logic coreRst,
  output logic aleOe,
  output logic psenOe,
  output logic relStrobe
);

  mcCtl_t ctl;
  logic   boundary;
  logic   sampledLow;

  mcrst_control u_ctl (
    .clk       (clk),
    .porN      (porN),
    .boundary  (boundary),
    .sampledLow(sampledLow),
    .wdtReq    (wdtReq),
    .ctl       (ctl)
  );

  mcrst_datapath #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .extRstN   (extRstN),
    .ctl       (ctl),
    .boundary  (boundary),
    .sampledLow(sampledLow),
    .coreRst   (coreRst),
    .aleOe     (aleOe),
    .psenOe    (psenOe),
    .relStrobe (relStrobe)
  );

endmodule

// File: rtl/mcrst_checker.sv
module mcrst_checker (
  input logic clk,
  input logic porN,
  input logic wdtReq,
  input logic boundary,
  input logic coreRst,
  input logic aleOe,
  input logic psenOe,
  input logic relStrobe
);

  // R8: both strobe pins become inputs exactly while reset is on
  assert_oe_follow_R8: assert property (@(posedge clk) disable iff (!porN)
    (aleOe == psenOe) && (aleOe != coreRst));

  // R7: a watchdog pulse forces reset on the next clock
  assert_wdt_forces_R7: assert property (@(posedge clk) disable iff (!porN)
    wdtReq |=> coreRst);

  // R9: release strobe lasts one clock
  assert_rel_single_R9: assert property (@(posedge clk) disable iff (!porN)
    relStrobe |=> !relStrobe);

  // R9: release strobe only right after reset dropped
  assert_rel_cause_R9: assert property (@(posedge clk) disable iff (!porN)
    relStrobe |-> (!coreRst && $past(coreRst)));

  // R3: reset not caused by the watchdog rises only after a boundary sample
  assert_rise_grid_R3: assert property (@(posedge clk) disable iff (!porN)
    ($rose(coreRst) && !$past(wdtReq)) |-> $past(boundary));

  // R2: boundaries are never adjacent
  assert_boundary_gap_R2: assert property (@(posedge clk) disable iff (!porN)
    boundary |=> !boundary);

endmodule

bind mc_reset_seq mcrst_checker u_chk (
  .clk      (clk),
  .porN     (porN),
  .wdtReq   (wdtReq),
  .boundary (boundary),
  .coreRst  (coreRst),
  .aleOe    (aleOe),
  .psenOe   (psenOe),
  .relStrobe(relStrobe)
);

// File: tb/mc_reset_seq_bench.sv
module mc_reset_seq_bench;

  localparam int CYC = 12;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic extRstN = 1'b0;
  logic wdtReq = 1'b0;
  logic coreRst, aleOe, psenOe, relStrobe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  mc_reset_seq u_mc_reset_seq (
    .clk(clk), .porN(porN), .extRstN(extRstN), .wdtReq(wdtReq),
    .coreRst(coreRst), .aleOe(aleOe), .psenOe(psenOe), .relStrobe(relStrobe)
  );

  // Reference model built from the requirements
  logic mS1, mS2, mPrev;
  int   mPh, mLow, mWdt;

  function automatic int nextLow(int low, logic syncVal);
    if (syncVal) return 0;
    return (low >= 2) ? 2 : low + 1;
  endfunction

  function automatic logic expReset(int low, int wdt);
    return (low == 2) || (wdt != 0);
  endfunction

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mS1 <= 1'b1; mS2 <= 1'b1; mPh <= 0; mLow <= 0; mWdt <= 0; mPrev <= 1'b0;
    end else begin
      mS1   <= extRstN;
      mS2   <= mS1;
      mPh   <= (mPh == CYC-1) ? 0 : mPh + 1;
      if (mPh == CYC-1) mLow <= nextLow(mLow, mS2);
      mWdt  <= wdtReq ? CYC : ((mWdt != 0) ? mWdt - 1 : 0);
      mPrev <= expReset(mLow, mWdt);
    end
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (porN && !finished) begin
      logic e;
      e = expReset(mLow, mWdt);
      check("R3 R5 R6 R7 coreRst", coreRst, e);
      check("R8 aleOe", aleOe, !e);
      check("R8 psenOe", psenOe, !e);
      check("R9 relStrobe", relStrobe, mPrev && !e);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int edges;
    int maxRst;
    int hi;
    void'($urandom(32'h1234_5eed));

    // R10: outputs during power-on init
    idle(3);
    check("R10 coreRst in init", coreRst, 0);
    check("R10 aleOe in init", aleOe, 1);
    check("R10 psenOe in init", psenOe, 1);
    check("R10 relStrobe in init", relStrobe, 0);

    // R1 R2 R3: ext held low across release, reset after the 24th edge
    porN = 1'b1;
    edges = 0;
    while (!coreRst && edges < 100) begin @(negedge clk); edges++; end
    check("R2 R3 edges to assertion", edges, 24);

    // R5 then R6: hold low, then release and measure drop window
    idle(40);
    check("R5 still held", coreRst, 1);
    extRstN = 1'b1;
    edges = 0;
    while (coreRst && edges < 100) begin @(negedge clk); edges++; end
    check("R6 drop within 3..14", int'(edges >= 3 && edges <= 14), 1);
    check("R9 strobe at release", relStrobe, 1);
    idle(30);

    // R4: low for exactly one machine cycle never resets
    for (int k = 0; k < 6; k++) begin
      idle(k);
      extRstN = 1'b0;
      idle(CYC);
      extRstN = 1'b1;
      maxRst = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (coreRst) maxRst = 1;
      end
      check("R4 single-sample glitch ignored", maxRst, 0);
    end

    // R7: watchdog pulse gives exactly one machine cycle
    wdtReq = 1'b1; @(negedge clk); wdtReq = 1'b0;
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      if (coreRst) hi++;
      @(negedge clk);
    end
    check("R7 watchdog width", hi, CYC + 1 - 1);

    // R7: watchdog while ext is low, independent of the pin
    extRstN = 1'b0; idle(5);
    wdtReq = 1'b1; @(negedge clk); wdtReq = 1'b0;
    check("R7 watchdog with ext low", coreRst, 1);
    idle(60);
    extRstN = 1'b1; idle(30);

    // Constrained random mix
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      len = $urandom_range(1, 40);
      extRstN = $urandom_range(0, 1);
      for (int i = 0; i < len; i++) begin
        wdtReq = ($urandom_range(0, 99) < 3);
        @(negedge clk);
      end
      wdtReq = 1'b0;
    end
    extRstN = 1'b1;
    idle(40);
    check("R6 idle after random", coreRst, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule